// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds recently used virtual-to-physical page mappings and searches every slot at once when a requester presents a virtual address, the current address-space tag and an access kind (read, write or execute). One cycle after the request strobe it reports one of three outcomes: a hit with the physical address, a protection fault when the mapping exists but its permission bits do not allow the access, or a miss. On a miss the block does nothing else. A separate handler walks the page tables, writes the mapping in through the insert port, and the requester then tries again.

Slots carry the address-space tag of the process they belong to, so mappings from several processes can be held at the same time, and two processes may map the same virtual page to the same frame. The lowest slots are reserved. Only an explicit pinned insert writes them, and neither eviction nor flush touches them. The remaining slots are refilled least-recently-used first. A flush clears every slot that is not pinned.

Top module: `xlat_cache`

## Requirements
- R1: After reset every output is 0 and no slot is valid, so a lookup of any address reports a miss.
- R2: A lookup hits when some slot is valid and both its page number (upper `VA_W-OFF_W` address bits) and its address-space tag equal the request's. The physical address is then the slot's frame number in the upper bits, joined to the request's low `OFF_W` offset bits.
- R3: A slot whose tag differs from the request's tag never hits. Two slots with the same page number and different tags coexist, and each hits only for its own tag.
- R4: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access code 0 is read, 1 is write, 2 is execute, and code 3 is never allowed. On a matching slot whose permission bits do not allow the access, `fault_o` is 1, `hit_o` is 0 and `paddr_o` is 0.
- R5: `done_o` is 1 exactly in the cycle after a cycle with `req_i` high. In that cycle exactly one of `hit_o`, `miss_o` and `fault_o` is 1, and `miss_o` is 1 when no slot matches. Outside such cycles all four are 0. A lookup sees the slot contents from before any same-cycle insert or flush.
- R6: A flush clears the valid bit of every slot with index at or above `N_PINNED`. Pinned slots keep their contents.
- R7: An unpinned insert whose page number and tag match a valid slot rewrites that slot, so no duplicate mapping is ever created.
- R8: An unpinned insert with no match goes to the lowest-indexed invalid unpinned slot. When all unpinned slots are valid, it replaces the unpinned slot that was least recently inserted or hit, where a faulting match also counts as a use. Pinned slots are never chosen.
- R9: A pinned insert writes slot `ins_slot_i` (below `N_PINNED`) and invalidates any other slot holding the same page number and tag.
- R10: When a flush and an insert arrive in the same cycle, the flush takes effect and the insert is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Lookup strobe |
| va_i | input | VA_W | Virtual address to translate |
| asid_i | input | ASID_W | Current address-space tag |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| ins_i | input | 1 | Insert strobe |
| ins_vpn_i | input | VA_W-OFF_W | Page number to insert |
| ins_asid_i | input | ASID_W | Address-space tag to insert |
| ins_pfn_i | input | PA_W-OFF_W | Frame number to insert |
| ins_perm_i | input | 3 | Permission bits {x,w,r} |
| ins_pin_i | input | 1 | Insert into a pinned slot |
| ins_slot_i | input | PIN_W | Pinned slot index |
| flush_i | input | 1 | Invalidate all unpinned slots |
| done_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | No matching slot |
| fault_o | output | 1 | Match with access not permitted |
| paddr_o | output | PA_W | Physical address on hit, else 0 |

## Verification
Directed sequences put one page under two tags, so a bench that ignored tags would fail the tag checks. They also sweep all four access codes over a read-only page, which separates a hit, a fault and a forbidden code. Filling every unpinned slot, touching the oldest and inserting one more shows whether the victim follows recency or slot order. A flush issued alongside an insert shows which of the two wins. A long seeded random mix of lookups, inserts over a small page and tag space that forces eviction, and rare flushes is compared against a recency-timestamp model of the slots.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  function automatic logic perm_ok(input logic [2:0] perm, input logic [1:0] acc);
    case (acc_e'(acc))
      ACC_READ:  return perm[PERM_R];
      ACC_WRITE: return perm[PERM_W];
      ACC_EXEC:  return perm[PERM_X];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N_ENTRIES = 32,
  parameter int VPN_W     = 4,
  parameter int ASID_W    = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]             vld_i,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N_ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]                 key_vpn_i,
  input  logic [ASID_W-1:0]                key_asid_i,
  output logic [N_ENTRIES-1:0]             hit_vec_o,
  output logic                             any_o,
  output logic [IDX_W-1:0]                 idx_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = vld_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end

  assign any_o = |hit_vec_o;

  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N_ENTRIES = 32,
  parameter int N_PINNED  = 2,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int N_UNP    = N_ENTRIES - N_PINNED,
  localparam int AGE_W    = (N_UNP > 1) ? $clog2(N_UNP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [IDX_W-1:0]     touch_idx_i,
  input  logic [N_ENTRIES-1:0] vld_i,
  output logic [IDX_W-1:0]     victim_o
);
  logic [AGE_W-1:0] age_q [N_UNP];
  logic             touch_unp;
  int               tu;
  logic [N_UNP-1:0] oldest_vec;

  assign touch_unp = touch_i && (touch_idx_i >= IDX_W'(N_PINNED));

  always_comb begin
    tu = 0;
    for (int u = 0; u < N_UNP; u++) begin
      if (touch_idx_i == IDX_W'(u + N_PINNED)) tu = u;
    end
  end

  // Ages stay a permutation of 0..N_UNP-1; the largest is the LRU slot.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < N_UNP; u++) age_q[u] <= AGE_W'(u);
    end else if (touch_unp) begin
      for (int u = 0; u < N_UNP; u++) begin
        if (u == tu)                 age_q[u] <= '0;
        else if (age_q[u] < age_q[tu]) age_q[u] <= age_q[u] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_UNP; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == AGE_W'(N_UNP - 1));
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = IDX_W'(N_PINNED);
    for (int u = 0; u < N_UNP; u++) begin
      if (!found && !vld_i[u + N_PINNED]) begin
        victim_o = IDX_W'(u + N_PINNED);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int u = 0; u < N_UNP; u++) begin
        if (oldest_vec[u]) victim_o = IDX_W'(u + N_PINNED);
      end
    end
  end

  assert_one_oldest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N_ENTRIES = 32,
  parameter int N_PINNED  = 2,
  parameter int VA_W      = 8,
  parameter int OFF_W     = 4,
  parameter int PA_W      = 8,
  parameter int ASID_W    = 4,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PFN_W    = PA_W - OFF_W,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int PIN_W    = (N_PINNED > 1) ? $clog2(N_PINNED) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [1:0]        acc_i,
  input  logic              ins_i,
  input  logic [VPN_W-1:0]  ins_vpn_i,
  input  logic [ASID_W-1:0] ins_asid_i,
  input  logic [PFN_W-1:0]  ins_pfn_i,
  input  logic [2:0]        ins_perm_i,
  input  logic              ins_pin_i,
  input  logic [PIN_W-1:0]  ins_slot_i,
  input  logic              flush_i,
  output logic              done_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic [PA_W-1:0]   paddr_o
);
  import xlat_pkg::*;

  logic [N_ENTRIES-1:0]             vld_q;
  logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [N_ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [N_ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [N_ENTRIES-1:0][2:0]        perm_q;

  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  assign lk_vpn = va_i[VA_W-1:OFF_W];
  assign lk_off = va_i[OFF_W-1:0];

  logic [N_ENTRIES-1:0] lk_vec, dup_vec;
  logic                 lk_any, dup_any;
  logic [IDX_W-1:0]     lk_idx, dup_idx, victim, tgt_idx;
  logic                 ins_eff, lk_ok;

  xlat_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) lk_match_i (
    .vld_i(vld_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lk_vpn), .key_asid_i(asid_i),
    .hit_vec_o(lk_vec), .any_o(lk_any), .idx_o(lk_idx)
  );

  xlat_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) ins_match_i (
    .vld_i(vld_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(ins_vpn_i), .key_asid_i(ins_asid_i),
    .hit_vec_o(dup_vec), .any_o(dup_any), .idx_o(dup_idx)
  );

  assign ins_eff = ins_i && !flush_i;
  assign lk_ok   = perm_ok(perm_q[lk_idx], acc_i);

  always_comb begin
    if (ins_pin_i)    tgt_idx = IDX_W'(ins_slot_i);
    else if (dup_any) tgt_idx = dup_idx;
    else              tgt_idx = victim;
  end

  xlat_lru #(.N_ENTRIES(N_ENTRIES), .N_PINNED(N_PINNED)) lru_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_i(ins_eff || (req_i && lk_any)),
    .touch_idx_i(ins_eff ? tgt_idx : lk_idx),
    .vld_i(vld_q),
    .victim_o(victim)
  );

  // Slot array
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      vpn_q  <= '0;
      asid_q <= '0;
      pfn_q  <= '0;
      perm_q <= '0;
    end else if (flush_i) begin
      for (int i = N_PINNED; i < N_ENTRIES; i++) vld_q[i] <= 1'b0;
    end else if (ins_i) begin
      if (ins_pin_i) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
          if (dup_vec[i] && (IDX_W'(i) != tgt_idx)) vld_q[i] <= 1'b0;
        end
      end
      vld_q[tgt_idx]  <= 1'b1;
      vpn_q[tgt_idx]  <= ins_vpn_i;
      asid_q[tgt_idx] <= ins_asid_i;
      pfn_q[tgt_idx]  <= ins_pfn_i;
      perm_q[tgt_idx] <= ins_perm_i;
    end
  end

  // Registered lookup result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      fault_o <= 1'b0;
      paddr_o <= '0;
    end else begin
      done_o  <= req_i;
      hit_o   <= req_i && lk_any && lk_ok;
      fault_o <= req_i && lk_any && !lk_ok;
      miss_o  <= req_i && !lk_any;
      paddr_o <= (req_i && lk_any && lk_ok) ? {pfn_q[lk_idx], lk_off} : '0;
    end
  end

  assert_done_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  assert_one_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({hit_o, miss_o, fault_o}));
  assert_quiet_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(hit_o || miss_o || fault_o));
  assert_fault_no_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (paddr_o == '0));
  assert_no_dup_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec));
  assert_pinned_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q[N_PINNED-1:0] == $past(vld_q[N_PINNED-1:0])));
  assert_flush_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q[N_ENTRIES-1:N_PINNED] == '0));
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int P  = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] va_i = '0;
  logic [3:0] asid_i = '0;
  logic [1:0] acc_i = '0;
  logic       ins_i = 1'b0;
  logic [3:0] ins_vpn_i = '0;
  logic [3:0] ins_asid_i = '0;
  logic [3:0] ins_pfn_i = '0;
  logic [2:0] ins_perm_i = '0;
  logic       ins_pin_i = 1'b0;
  logic [0:0] ins_slot_i = '0;
  logic       flush_i = 1'b0;
  logic       done_o, hit_o, miss_o, fault_o;
  logic [7:0] paddr_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xlat_cache dut_i (
    .clk_i, .rst_ni, .req_i, .va_i, .asid_i, .acc_i,
    .ins_i, .ins_vpn_i, .ins_asid_i, .ins_pfn_i, .ins_perm_i,
    .ins_pin_i, .ins_slot_i, .flush_i,
    .done_o, .hit_o, .miss_o, .fault_o, .paddr_o
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference model
  bit         m_vld  [N];
  logic [3:0] m_vpn  [N];
  logic [3:0] m_asid [N];
  logic [3:0] m_pfn  [N];
  logic [2:0] m_perm [N];
  int         m_ts   [N];
  int         tick = 1;

  function automatic int m_find(logic [3:0] vpn, logic [3:0] asid);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int v = P;
    for (int i = P; i < N; i++) if (!m_vld[i]) return i;
    for (int i = P; i < N; i++) if (m_ts[i] < m_ts[v]) v = i;
    return v;
  endfunction

  function automatic bit m_allow(logic [2:0] perm, logic [1:0] acc);
    if (acc == 2'd3) return 1'b0;
    return perm[acc];
  endfunction

  task automatic check(bit ok, string rq, logic [11:0] act, logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Drives at a falling edge, checks at the following falling edge.
  task automatic do_lookup(logic [7:0] va, logic [3:0] asid, logic [1:0] acc, string tag);
    int          idx;
    logic [11:0] exp, act;
    string       rq;
    idx = m_find(va[7:4], asid);
    if (idx < 0)                         begin exp = {4'b1010, 8'h00}; rq = "R5"; end
    else if (m_allow(m_perm[idx], acc))  begin exp = {4'b1100, m_pfn[idx], va[3:0]}; rq = "R2"; end
    else                                 begin exp = {4'b1001, 8'h00}; rq = "R4"; end
    if (tag != "") rq = tag;
    req_i = 1'b1; va_i = va; asid_i = asid; acc_i = acc;
    @(posedge clk_i);
    if (idx >= P) m_ts[idx] = tick++;
    @(negedge clk_i);
    req_i = 1'b0;
    act = {done_o, hit_o, miss_o, fault_o, paddr_o};
    check(act == exp, rq, act, exp);
  endtask

  task automatic do_insert(logic [3:0] vpn, logic [3:0] asid, logic [3:0] pfn,
                           logic [2:0] perm, bit pin, bit slot);
    int t;
    ins_i = 1'b1; ins_vpn_i = vpn; ins_asid_i = asid; ins_pfn_i = pfn;
    ins_perm_i = perm; ins_pin_i = pin; ins_slot_i = slot;
    @(posedge clk_i);
    if (pin) begin
      t = slot;
      for (int i = 0; i < N; i++)
        if (i != t && m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) m_vld[i] = 0;
    end else begin
      t = m_find(vpn, asid);
      if (t < 0) t = m_victim();
      m_ts[t] = tick++;
    end
    m_vld[t] = 1; m_vpn[t] = vpn; m_asid[t] = asid; m_pfn[t] = pfn; m_perm[t] = perm;
    @(negedge clk_i);
    ins_i = 1'b0; ins_pin_i = 1'b0;
  endtask

  task automatic do_flush();
    flush_i = 1'b1;
    @(posedge clk_i);
    for (int i = P; i < N; i++) m_vld[i] = 0;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] act;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_ts[i] = 0; end
    repeat (3) @(negedge clk_i);
    act = {done_o, hit_o, miss_o, fault_o, paddr_o};
    check(act == 12'h000, "R1", act, 12'h000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    act = {done_o, hit_o, miss_o, fault_o, paddr_o};
    check(act == 12'h000, "R1", act, 12'h000);
    do_lookup(8'h35, 4'd1, 2'd0, "R1");

    // Basic hit
    do_insert(4'h3, 4'd1, 4'hA, 3'b111, 0, 0);
    do_lookup(8'h35, 4'd1, 2'd0, "R2");
    do_lookup(8'h3F, 4'd1, 2'd2, "R2");
    // Tag separation and shared frame
    do_lookup(8'h35, 4'd2, 2'd0, "R3");
    do_insert(4'h3, 4'd2, 4'hA, 3'b111, 0, 0);
    do_lookup(8'h31, 4'd2, 2'd1, "R3");
    do_lookup(8'h32, 4'd1, 2'd1, "R3");
    // Permissions on a read-only page
    do_insert(4'h5, 4'd1, 4'h7, 3'b001, 0, 0);
    for (int a = 0; a < 4; a++) do_lookup(8'h5C, 4'd1, 2'(a), "R4");
    // Overwrite of an existing mapping
    do_insert(4'h3, 4'd1, 4'hC, 3'b111, 0, 0);
    do_lookup(8'h36, 4'd1, 2'd0, "R7");
    // Pinned slot survives flush
    do_insert(4'hF, 4'd0, 4'h1, 3'b101, 1, 0);
    do_flush();
    do_lookup(8'hF4, 4'd0, 2'd2, "R6");
    do_lookup(8'h36, 4'd1, 2'd0, "R6");
    // Pinned insert removes a same-key unpinned slot
    do_insert(4'h9, 4'd3, 4'h2, 3'b111, 0, 0);
    do_insert(4'h9, 4'd3, 4'h4, 3'b111, 1, 1);
    do_lookup(8'h90, 4'd3, 2'd0, "R9");
    do_flush();
    do_lookup(8'h90, 4'd3, 2'd0, "R9");
    // Fill all unpinned slots, touch oldest, evict next-oldest
    for (int i = 0; i < N - P; i++) do_insert(4'(i % 16), 4'(4 + i / 16), 4'(i), 3'b111, 0, 0);
    do_lookup(8'h00, 4'd4, 2'd0, "R8");
    do_insert(4'h0, 4'd9, 4'hE, 3'b111, 0, 0);
    do_lookup(8'h10, 4'd4, 2'd0, "R8");
    do_lookup(8'h00, 4'd4, 2'd0, "R8");
    do_lookup(8'h03, 4'd9, 2'd0, "R8");
    // Flush wins over a same-cycle insert
    flush_i = 1'b1; ins_i = 1'b1; ins_vpn_i = 4'h6; ins_asid_i = 4'd6;
    ins_pfn_i = 4'h6; ins_perm_i = 3'b111; ins_pin_i = 1'b0;
    @(posedge clk_i);
    for (int i = P; i < N; i++) m_vld[i] = 0;
    @(negedge clk_i);
    flush_i = 1'b0; ins_i = 1'b0;
    do_lookup(8'h60, 4'd6, 2'd0, "R10");
    do_lookup(8'hF0, 4'd0, 2'd0, "R10");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40)
        do_insert(4'($urandom_range(0, 15)), 4'($urandom_range(0, 3)),
                  4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)), 0, 0);
      else if (r < 43)
        do_flush();
      else
        do_lookup(8'($urandom_range(0, 255)), 4'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), "");
    end
    finish_run();
  end
endmodule